// File: doc/BRIEF.md
# Transition-Triggered Coefficient Sequencer

This block produces the time-varying coefficients for a cascade of two second-order filter sections. Each accepted input sample is compared against a programmable signed threshold. When the result of that comparison differs from the result for the previous accepted sample, the input has made a binary transition. The block marks that transition and restarts a sweep through constant coefficient tables. Each section uses two 16-bit coefficients, so four values go out with every output beat.

The sweep advances one table entry per accepted sample. It stops on the last entry and does not wrap. That last entry is the steady-state coefficient set, and the outputs hold it until the next transition restarts the sweep at entry zero. After reset the sweep is already stopped, so the outputs carry steady-state values until the first transition.

Samples enter on a valid/ready stream and coefficient beats leave on a valid/ready stream. There is one output register. An input sample is accepted only when the output register is empty or is being drained in the same cycle, so back-pressure on the output stalls the input. A stalled sample is not consumed and does not touch the comparator history or the sweep position. The threshold is a plain control input.

Top module: `coef_sweep_top`

## Requirements
- R1: A sample counts as high when it is strictly greater than `thresh`, both read as signed 16-bit values; equal or lower counts as low. The comparator history is low after reset.
- R2: An accepted sample whose high/low result differs from the previous accepted sample's result produces a beat with `m_edge`=1 and table index 0. Otherwise `m_edge`=0.
- R3: An accepted sample with no transition, while the index is below LEN-1, produces a beat whose index is one greater than the previous beat's index.
- R4: The index never exceeds LEN-1. With no transition at LEN-1 the index stays at LEN-1, so the last entry is repeated.
- R5: After reset the sweep is stopped at LEN-1, so beats from samples without a transition carry entry LEN-1.
- R6: A transition restarts the sweep at index 0 whether the sweep is mid-way or stopped; the restart takes priority over advancing or holding.
- R7: Coefficient k (k = 0..3) sits at bits [16k+15:16k] of `m_coef`. k=0,1 belong to section A and k=2,3 to section B. In the default tables, coefficient k of entry i equals k*4096 + i.
- R8: `s_ready` = !`m_valid` || `m_ready`. While `m_valid`=1 and `m_ready`=0, `m_coef` and `m_edge` stay stable, and an offered sample is not accepted: the index and the comparator history do not change.
- R9: The beat for an accepted sample appears with `m_valid`=1 in the cycle after acceptance. `m_valid` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thresh | input | 16 | Signed comparison threshold |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can accept a sample |
| s_data | input | 16 | Signed input sample |
| m_valid | output | 1 | Coefficient beat valid |
| m_ready | input | 1 | Downstream accepts beat |
| m_coef | output | 64 | Four packed coefficients |
| m_edge | output | 1 | Beat started a new sweep |

## Verification
Every beat is due exactly one clock after its sample is accepted, because only the output register lies between acceptance and the output ports. The bench therefore drives each sample before a rising edge and reads `m_valid`, `m_edge` and all four coefficients at the following falling edge. During a stall the beat must stay unchanged for as many cycles as `m_ready` is held low. When `m_ready` is raised, the held beat drains and the waiting sample is accepted on the same edge, and the new beat is read one falling edge later.

// File: rtl/coef_sweep_pkg.sv
package coef_sweep_pkg;
  localparam int CW      = 16;
  localparam int NSEC    = 2;
  localparam int PER_SEC = 2;
  localparam int NCOEF   = NSEC * PER_SEC;

  // default table content: coefficient k of entry i
  function automatic logic [CW-1:0] tbl_entry(input int k, input int i);
    return CW'(k * 4096 + i);
  endfunction
endpackage

// File: rtl/coef_cross_det.sv
module coef_cross_det #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic signed [DW-1:0] data,
  input  logic signed [DW-1:0] thresh,
  output logic                 pulse
);
  logic above;
  logic above_q;

  assign above = data > thresh;
  assign pulse = above ^ above_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    above_q <= 1'b0;
    else if (fire) above_q <= above;
  end

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(above_q)); // R8
endmodule

// File: rtl/coef_addr_ctr.sv
module coef_addr_ctr #(
  parameter int LEN = 256,
  localparam int AW = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          restart,
  output logic [AW-1:0] sel
);
  localparam logic [AW-1:0] LAST = AW'(LEN - 1);
  logic [AW-1:0] addr_q;

  always_comb begin
    if (restart)             sel = '0;
    else if (addr_q == LAST) sel = LAST;
    else                     sel = addr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    addr_q <= LAST;
    else if (fire) addr_q <= sel;
  end

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_q <= LAST); // R4
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fire && restart |=> addr_q == '0); // R6
  AST_HOLD_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !restart && addr_q == LAST |=> addr_q == LAST); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !restart && addr_q != LAST |=> addr_q == $past(addr_q) + 1'b1); // R3
  AST_NO_MOVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(addr_q)); // R8
endmodule

// File: rtl/coef_rom_bank.sv
module coef_rom_bank
  import coef_sweep_pkg::*;
#(
  parameter int LEN = 256,
  localparam int AW = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic [AW-1:0]       sel,
  output logic [NCOEF*CW-1:0] coef
);
  for (genvar k = 0; k < NCOEF; k++) begin : g_tbl
    logic [CW-1:0] rom [LEN];
    for (genvar i = 0; i < LEN; i++) begin : g_ent
      assign rom[i] = tbl_entry(k, i);
    end
    assign coef[k*CW +: CW] = rom[sel];
  end
endmodule

// File: rtl/coef_sweep_top.sv
module coef_sweep_top
  import coef_sweep_pkg::*;
#(
  parameter int LEN = 256,
  localparam int AW = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [CW-1:0]    thresh,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic signed [CW-1:0]    s_data,
  output logic                    m_valid,
  input  logic                    m_ready,
  output logic [NCOEF*CW-1:0]     m_coef,
  output logic                    m_edge
);
  logic                   fire;
  logic                   pulse;
  logic [AW-1:0]          sel;
  logic [NCOEF*CW-1:0]    coef_rd;

  assign s_ready = !m_valid || m_ready;
  assign fire    = s_valid && s_ready;

  coef_cross_det #(.DW(CW)) u_det (
    .clk(clk), .rst_n(rst_n), .fire(fire),
    .data(s_data), .thresh(thresh), .pulse(pulse)
  );

  coef_addr_ctr #(.LEN(LEN)) u_ctr (
    .clk(clk), .rst_n(rst_n), .fire(fire),
    .restart(pulse), .sel(sel)
  );

  coef_rom_bank #(.LEN(LEN)) u_rom (
    .sel(sel), .coef(coef_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_coef  <= '0;
      m_edge  <= 1'b0;
    end else if (fire) begin
      m_valid <= 1'b1;
      m_coef  <= coef_rd;
      m_edge  <= pulse;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_coef) && $stable(m_edge)); // R8
  AST_BEAT_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> m_valid); // R9
  AST_EDGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_edge |-> m_coef[CW-1:0] == '0); // R2
endmodule

// File: tb/coef_sweep_top_bench.sv
module coef_sweep_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LEN = 16;
  localparam int NV  = 24;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic signed [15:0] thresh = '0;
  logic               s_valid = 1'b0;
  logic               s_ready;
  logic signed [15:0] s_data = '0;
  logic               m_valid;
  logic               m_ready = 1'b1;
  logic [63:0]        m_coef;
  logic               m_edge;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coef_sweep_top #(.LEN(LEN)) u_coef_sweep_top (
    .clk(clk), .rst_n(rst_n), .thresh(thresh),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_coef(m_coef), .m_edge(m_edge)
  );

  // stimulus vectors, threshold 0: data, expected index, expected edge
  localparam logic signed [15:0] VDATA [NV] = '{
    -16'sd5, -16'sd3, 16'sd100, 16'sd50, 16'sd20, -16'sd1, -16'sd2, -16'sd7,
    -16'sd7, -16'sd7, -16'sd7, -16'sd7, -16'sd7, -16'sd7, -16'sd7, -16'sd7,
    -16'sd7, -16'sd7, -16'sd7, -16'sd7, -16'sd7, -16'sd7, 16'sd0, 16'sd1 };
  localparam int VIDX [NV] = '{
    15, 15, 0, 1, 2, 0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10,
    11, 12, 13, 14, 15, 15, 15, 0 };
  localparam bit VEDGE [NV] = '{
    0, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0,
    0, 0, 0, 0, 0, 0, 0, 1 };

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_coef(input int idx);
    logic [63:0] v;
    for (int k = 0; k < 4; k++) v[k*16 +: 16] = 16'(k * 4096 + idx);
    return v;
  endfunction

  task automatic check_beat(input string tag, input int idx, input bit edg);
    check(m_valid == 1'b1, {tag, " R9 valid"}, longint'(m_valid), 1);
    check(m_edge == edg, {tag, " R2 edge"}, longint'(m_edge), longint'(edg));
    check(m_coef == exp_coef(idx), {tag, " R7 coef"}, longint'(m_coef), longint'(exp_coef(idx)));
  endtask

  // drive one sample with m_ready high, read beat one edge later
  task automatic send(input logic signed [15:0] d, input int idx, input bit edg, input string tag);
    @(negedge clk);
    s_data = d;
    s_valid = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    check_beat(tag, idx, edg);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state, R9 and R8
    check(m_valid == 1'b0, "R9 reset valid", longint'(m_valid), 0);
    check(s_ready == 1'b1, "R8 reset ready", longint'(s_ready), 1);
    rst_n = 1'b1;

    // table walk: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      send(VDATA[v], VIDX[v], VEDGE[v], $sformatf("vec%0d R3 R4", v));
    end

    // R8 stall: history is high, index 0
    @(negedge clk);
    m_ready = 1'b0;
    s_data = 16'sd5;
    s_valid = 1'b1;
    @(negedge clk);
    check_beat("R8 stalled beat", 1, 1'b0);
    s_data = -16'sd5;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(s_ready == 1'b0, "R8 ready low", longint'(s_ready), 0);
      check_beat("R8 held beat", 1, 1'b0);
    end
    m_ready = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    check_beat("R8 released sample R6", 0, 1'b1);

    // R1 threshold move: low history, -5 above -10
    thresh = -16'sd10;
    send(-16'sd5, 0, 1'b1, "R1 new thresh");
    send(-16'sd10, 0, 1'b1, "R1 equal is low");
    send(-16'sd11, 1, 1'b0, "R1 below");

    // R5 mid-sweep reset
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(m_valid == 1'b0, "R9 reset mid-run", longint'(m_valid), 0);
    rst_n = 1'b1;
    send(-16'sd20, LEN - 1, 1'b0, "R5 after reset");
    send(-16'sd20, LEN - 1, 1'b0, "R4 R5 hold");
    send(16'sd20, 0, 1'b1, "R6 restart from end");
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R9 actual=%0d expected=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule